// File: doc/BRIEF.md
# Acquire/Release Cache Walk Sequencer

This block sits between a request source and a small L1 data cache. Memory-ordering requests reach the cache through it. A release-ordered request makes it walk every line index and emit one flush (writeback) request per line. An acquire-ordered request makes it walk every line index and emit one invalidate request per line. A request that carries both orderings gets a complete invalidate walk, followed by a complete flush walk. Maintenance requests go out one per clock on a valid/ready port, tagged with the line index and an operation bit.

Two counters track outstanding flushes and outstanding invalidates. Each increments on a completed maintenance handshake and decrements on an acknowledge pulse. Normal request issue is held off only while flushes are outstanding. Outstanding invalidates never stall it.

Kernel-scope requests get special handling. A kernel-end stores its context number in a small pending list. When the flush count drains to zero, every stored context is reported finished in a single pulse, as a one-hot-per-context mask, and the list empties. A kernel-begin starts an invalidate walk.

Top module: `acqrel_walk_seq`

## Requirements
- R1: A release request (`req_rel`=1, `req_acq`=0, `req_kern`=0), once accepted on the issue path, produces a walk over line indices 0, 1, ..., NUM_LINES-1. The walk emits one maintenance request per index with `mnt_op`=1 (flush), in index order. `wb_outstanding` rises by one per completed `mnt_valid`/`mnt_ready` handshake. `mnt_line` and `mnt_op` hold steady while `mnt_ready` is low.
- R2: An acquire request (`req_acq`=1, `req_rel`=0, `req_kern`=0), once accepted, produces the same walk with `mnt_op`=0 (invalidate). `inv_outstanding` rises by one per handshake.
- R3: A request with `req_acq`=1 and `req_rel`=1 (not kernel scope) produces a complete invalidate walk first, then a complete flush walk. The result is 2*NUM_LINES handshakes, and no flush precedes the last invalidate.
- R4: While `wb_outstanding` is nonzero, `iss_valid` stays low and non-kernel requests see `req_ready`=0. Issue resumes on its own in the cycle after the count returns to zero.
- R5: Each `wb_ack` pulse lowers `wb_outstanding` by one. A `wb_ack` while the count is zero raises `wb_err` in that cycle, and the count stays at zero.
- R6: A nonzero `inv_outstanding` never blocks issue. An `inv_ack` pulse only lowers `inv_outstanding`.
- R7: With no flush outstanding, a kernel-end request (`req_kern`=1, `req_rel`=1) bypasses the issue port. It stores `req_ctx` and starts a flush walk. When `wb_outstanding` reaches zero, `kend_done` pulses for one cycle with `kend_mask` bit i set for every stored context i, and the list is cleared.
- R8: While flushes are outstanding, kernel-scope requests are accepted without reaching the issue port. A kernel-end is only stored and starts no walk.
- R9: While flushes are outstanding, a kernel-begin (`req_kern`=1, `req_acq`=1, `req_rel`=0) starts an invalidate walk only if `inv_outstanding` is zero.
- R10: With no flush outstanding, a kernel-begin goes to the issue port. Its invalidate walk starts only after `iss_ready` accepts it.
- R11: When the pending list holds KEND_DEPTH contexts, a further kernel-end sees `req_ready`=0.
- R12: After reset, both counts are zero and `mnt_valid`, `iss_valid`, `kend_done` and `wb_err` are low. While a walk is running, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted |
| req_acq | input | 1 | Request has acquire ordering |
| req_rel | input | 1 | Request has release ordering |
| req_kern | input | 1 | Request is kernel scope (begin/end marker) |
| req_ctx | input | CTX_W | Context number of the request |
| iss_valid | output | 1 | Request offered to the normal issue path |
| iss_ready | input | 1 | Normal issue path takes the request |
| mnt_valid | output | 1 | Maintenance request valid |
| mnt_ready | input | 1 | Maintenance request taken |
| mnt_line | output | LINE_W | Line index of the maintenance request |
| mnt_op | output | 1 | 0 = invalidate, 1 = flush |
| wb_ack | input | 1 | One flush completed |
| inv_ack | input | 1 | One invalidate completed |
| wb_outstanding | output | CNT_W | Outstanding flush count |
| inv_outstanding | output | CNT_W | Outstanding invalidate count |
| wb_err | output | 1 | Flush acknowledge arrived with a zero count |
| kend_done | output | 1 | Pending kernel-ends complete this cycle |
| kend_mask | output | 2**CTX_W | Contexts completed by this pulse |

## Verification
The main function is driven with six request kinds: plain, acquire, release, combined acquire-release, kernel-begin and kernel-end. Each kind is checked for its number of invalidate and flush handshakes, for whether it reaches the issue port, and for whether it yields a completion mask. These six together separate the three walk shapes and the two routing paths. Directed cases then hold acknowledges back to show the following:
- flush counts gate issue and invalidate counts do not;
- kernel requests arriving mid-flush are only recorded;
- a second kernel-begin is suppressed while invalidates are pending;
- the pending list back-pressures when full;
- an acknowledge at zero is flagged and the count does not wrap.

// File: rtl/acqrel_pkg.sv
package acqrel_pkg;

    typedef enum logic {
        MNT_INVAL = 1'b0,
        MNT_FLUSH = 1'b1
    } mnt_op_e;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_INV   = 2'd1,
        WALK_FLUSH = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic acq;
        logic rel;
        logic kern;
    } order_attr_t;

    typedef struct packed {
        logic start_inv;
        logic start_flush;
        logic push_ctx;
        logic to_issue;
    } walk_cmd_t;

    function automatic logic is_kernel_end(order_attr_t a);
        return a.kern && a.rel;
    endfunction

    function automatic logic is_kernel_begin(order_attr_t a);
        return a.kern && a.acq && !a.rel;
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/acqrel_line_walker.sv
module acqrel_line_walker
    import acqrel_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned LINE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_inv,
    input  logic              start_flush,
    input  logic              mnt_ready,
    output logic              mnt_valid,
    output logic [LINE_W-1:0] mnt_line,
    output mnt_op_e           mnt_op,
    output logic              busy,
    output logic              flushing
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    walk_state_e       state_q;
    logic [LINE_W-1:0] line_q;
    logic              chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            line_q  <= '0;
            chain_q <= 1'b0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    line_q <= '0;
                    if (start_inv) begin
                        state_q <= WALK_INV;
                        chain_q <= start_flush;
                    end else if (start_flush) begin
                        state_q <= WALK_FLUSH;
                        chain_q <= 1'b0;
                    end
                end
                WALK_INV: begin
                    if (mnt_ready) begin
                        if (line_q == LAST_LINE) begin
                            line_q  <= '0;
                            chain_q <= 1'b0;
                            state_q <= chain_q ? WALK_FLUSH : WALK_IDLE;
                        end else begin
                            line_q <= line_q + 1'b1;
                        end
                    end
                end
                WALK_FLUSH: begin
                    if (mnt_ready) begin
                        if (line_q == LAST_LINE) begin
                            line_q  <= '0;
                            state_q <= WALK_IDLE;
                        end else begin
                            line_q <= line_q + 1'b1;
                        end
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    assign mnt_valid = (state_q != WALK_IDLE);
    assign mnt_line  = line_q;
    assign mnt_op    = (state_q == WALK_FLUSH) ? MNT_FLUSH : MNT_INVAL;
    assign busy      = (state_q != WALK_IDLE);
    assign flushing  = (state_q == WALK_FLUSH);

endmodule

// File: rtl/acqrel_ack_counter.sv
module acqrel_ack_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count     = cnt_q;
    assign underflow = dec && !inc && (cnt_q == '0);

endmodule

// File: rtl/acqrel_kend_list.sv
module acqrel_kend_list #(
    parameter int unsigned CTX_W = 3,
    parameter int unsigned DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic [CTX_W-1:0]    push_ctx,
    input  logic                drain,
    output logic                full,
    output logic                empty,
    output logic [2**CTX_W-1:0] done_mask
);
    localparam int unsigned NUM_CTX = 2 ** CTX_W;
    localparam int unsigned OCC_W   = $clog2(DEPTH + 1);

    logic [CTX_W-1:0] slot_q [DEPTH];
    logic [OCC_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (drain) begin
            occ_q <= push ? OCC_W'(1) : '0;
            if (push) slot_q[0] <= push_ctx;
        end else if (push && !full) begin
            slot_q[occ_q] <= push_ctx;
            occ_q         <= occ_q + 1'b1;
        end
    end

    always_comb begin
        done_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (OCC_W'(i) < occ_q) done_mask[slot_q[i]] = 1'b1;
        end
    end

    assign full  = (occ_q == OCC_W'(DEPTH));
    assign empty = (occ_q == '0);

    logic unused_ok;
    assign unused_ok = (NUM_CTX > 0);

endmodule

// File: rtl/acqrel_walk_seq.sv
module acqrel_walk_seq
    import acqrel_pkg::*;
#(
    parameter int unsigned NUM_LINES    = 8,
    parameter int unsigned CTX_W        = 3,
    parameter int unsigned KEND_DEPTH   = 4,
    parameter int unsigned CNT_HEADROOM = 3,
    parameter int unsigned LINE_W       = idx_width(NUM_LINES),
    parameter int unsigned CNT_W        = idx_width(NUM_LINES) + 1 + CNT_HEADROOM
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_acq,
    input  logic                req_rel,
    input  logic                req_kern,
    input  logic [CTX_W-1:0]    req_ctx,
    output logic                iss_valid,
    input  logic                iss_ready,
    output logic                mnt_valid,
    input  logic                mnt_ready,
    output logic [LINE_W-1:0]   mnt_line,
    output logic                mnt_op,
    input  logic                wb_ack,
    input  logic                inv_ack,
    output logic [CNT_W-1:0]    wb_outstanding,
    output logic [CNT_W-1:0]    inv_outstanding,
    output logic                wb_err,
    output logic                kend_done,
    output logic [2**CTX_W-1:0] kend_mask
);
    order_attr_t attr;
    walk_cmd_t   cmd;
    mnt_op_e     op_e;
    logic        walk_busy, walk_flushing;
    logic        kend_full, kend_empty, kend_drain;
    logic        flush_hs, inv_hs;
    logic        wb_pending;
    logic        accept;
    logic        inv_unused_flag;

    assign attr = '{acq: req_acq, rel: req_rel, kern: req_kern};
    assign wb_pending = (wb_outstanding != '0);

    // Request routing: decide where an incoming request goes this cycle.
    always_comb begin
        cmd       = '0;
        req_ready = 1'b0;
        accept    = 1'b0;
        if (!walk_busy) begin
            if (wb_pending) begin
                // Flushes draining: only kernel-scope markers pass.
                if (attr.kern) begin
                    req_ready = !(attr.rel && kend_full);
                    accept    = req_valid && req_ready;
                    if (accept) begin
                        cmd.start_inv = attr.acq && (inv_outstanding == '0);
                        cmd.push_ctx  = attr.rel;
                    end
                end
            end else if (is_kernel_end(attr)) begin
                req_ready = !kend_full;
                accept    = req_valid && req_ready;
                if (accept) begin
                    cmd.push_ctx    = 1'b1;
                    cmd.start_flush = 1'b1;
                end
            end else begin
                cmd.to_issue = req_valid;
                req_ready    = iss_ready;
                accept       = req_valid && iss_ready;
                if (accept) begin
                    if (is_kernel_begin(attr)) begin
                        cmd.start_inv = 1'b1;
                    end else if (attr.acq && attr.rel) begin
                        cmd.start_inv   = 1'b1;
                        cmd.start_flush = 1'b1;
                    end else if (attr.rel) begin
                        cmd.start_flush = 1'b1;
                    end else if (attr.acq) begin
                        cmd.start_inv = 1'b1;
                    end
                end
            end
        end
    end

    assign iss_valid = cmd.to_issue;

    acqrel_line_walker #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_walker (
        .clk         (clk),
        .rst         (rst),
        .start_inv   (cmd.start_inv),
        .start_flush (cmd.start_flush),
        .mnt_ready   (mnt_ready),
        .mnt_valid   (mnt_valid),
        .mnt_line    (mnt_line),
        .mnt_op      (op_e),
        .busy        (walk_busy),
        .flushing    (walk_flushing)
    );

    assign mnt_op   = op_e;
    assign flush_hs = mnt_valid && mnt_ready && (op_e == MNT_FLUSH);
    assign inv_hs   = mnt_valid && mnt_ready && (op_e == MNT_INVAL);

    acqrel_ack_counter #(.CNT_W(CNT_W)) u_wb_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc       (flush_hs),
        .dec       (wb_ack),
        .count     (wb_outstanding),
        .underflow (wb_err)
    );

    acqrel_ack_counter #(.CNT_W(CNT_W)) u_inv_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc       (inv_hs),
        .dec       (inv_ack),
        .count     (inv_outstanding),
        .underflow (inv_unused_flag)
    );

    // Batch completion once every flush has been acknowledged.
    assign kend_drain = !kend_empty && !wb_pending && !walk_flushing;

    acqrel_kend_list #(
        .CTX_W (CTX_W),
        .DEPTH (KEND_DEPTH)
    ) u_kend (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd.push_ctx),
        .push_ctx  (req_ctx),
        .drain     (kend_drain),
        .full      (kend_full),
        .empty     (kend_empty),
        .done_mask (kend_mask)
    );

    assign kend_done = kend_drain;

    logic unused_sink;
    assign unused_sink = inv_unused_flag;

endmodule

// File: rtl/acqrel_walk_seq_chk.sv
module acqrel_walk_seq_chk #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned LINE_W    = 3,
    parameter int unsigned CNT_W     = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_kern,
    input logic              req_rel,
    input logic              iss_valid,
    input logic              mnt_valid,
    input logic              mnt_ready,
    input logic [LINE_W-1:0] mnt_line,
    input logic              mnt_op,
    input logic              wb_ack,
    input logic [CNT_W-1:0]  wb_outstanding,
    input logic [CNT_W-1:0]  inv_outstanding,
    input logic              kend_done,
    input logic              kend_full
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    AST_MNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mnt_valid && !mnt_ready) |=> (mnt_valid && $stable(mnt_line) && $stable(mnt_op))); // R1

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mnt_valid && mnt_ready && mnt_line != LAST_LINE)
        |=> (mnt_valid && mnt_line == LINE_W'($past(mnt_line) + 1'b1))); // R1

    AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (rst)
        (wb_outstanding != '0) |-> !iss_valid); // R4

    AST_WB_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (wb_ack && wb_outstanding == '0 && !(mnt_valid && mnt_ready && mnt_op))
        |=> (wb_outstanding == '0)); // R5

    AST_INV_NOBLOCK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kern && !mnt_valid && wb_outstanding == '0 && inv_outstanding != '0)
        |-> iss_valid); // R6

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        kend_done |-> (wb_outstanding == '0)); // R7

    AST_KEND_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (kend_full && req_kern && req_rel) |-> !req_ready); // R11

    AST_WALK_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mnt_valid |-> !req_ready); // R12

endmodule

bind acqrel_walk_seq acqrel_walk_seq_chk #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_kern        (req_kern),
    .req_rel         (req_rel),
    .iss_valid       (iss_valid),
    .mnt_valid       (mnt_valid),
    .mnt_ready       (mnt_ready),
    .mnt_line        (mnt_line),
    .mnt_op          (mnt_op),
    .wb_ack          (wb_ack),
    .wb_outstanding  (wb_outstanding),
    .inv_outstanding (inv_outstanding),
    .kend_done       (kend_done),
    .kend_full       (kend_full)
);

// File: tb/tb_acqrel_walk_seq.sv
`timescale 1ns/1ps
module tb_acqrel_walk_seq;
    localparam int NL    = 8;
    localparam int CTXW  = 3;
    localparam int LW    = 3;
    localparam int CW    = 3 + 1 + 3;
    localparam int NCTX  = 8;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_ready, req_acq, req_rel, req_kern;
    logic [CTXW-1:0] req_ctx;
    logic iss_valid, iss_ready;
    logic mnt_valid, mnt_ready, mnt_op;
    logic [LW-1:0] mnt_line;
    logic wb_ack, inv_ack, wb_err, kend_done;
    logic [CW-1:0] wb_outstanding, inv_outstanding;
    logic [NCTX-1:0] kend_mask;

    always #4 clk = ~clk;

    acqrel_walk_seq dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_acq(req_acq), .req_rel(req_rel), .req_kern(req_kern), .req_ctx(req_ctx),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .mnt_valid(mnt_valid), .mnt_ready(mnt_ready), .mnt_line(mnt_line), .mnt_op(mnt_op),
        .wb_ack(wb_ack), .inv_ack(inv_ack),
        .wb_outstanding(wb_outstanding), .inv_outstanding(inv_outstanding),
        .wb_err(wb_err), .kend_done(kend_done), .kend_mask(kend_mask)
    );

    int errors = 0;
    int checks = 0;
    int inv_seen, flush_seen, iss_seen, done_seen, seq_bad;
    logic [NCTX-1:0] last_mask;

    // Port monitor: counts handshakes seen at each rising edge.
    always @(posedge clk) begin
        if (!rst) begin
            if (mnt_valid && mnt_ready) begin
                if (mnt_op) begin
                    if (int'(mnt_line) != (flush_seen % NL)) seq_bad++;
                    flush_seen++;
                end else begin
                    if (int'(mnt_line) != (inv_seen % NL)) seq_bad++;
                    if (flush_seen != 0) seq_bad++;
                    inv_seen++;
                end
            end
            if (iss_valid && iss_ready) iss_seen++;
            if (kend_done) begin
                done_seen++;
                last_mask = kend_mask;
            end
        end
    end

    task automatic clear_mon();
        inv_seen = 0; flush_seen = 0; iss_seen = 0; done_seen = 0; seq_bad = 0; last_mask = '0;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic a, input logic r, input logic k, input int ctx, output logic acc);
        acc = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_acq = a; req_rel = r; req_kern = k; req_ctx = CTXW'(ctx);
        for (int t = 0; t < 40; t++) begin
            #1;
            if (req_ready) begin
                @(posedge clk);
                acc = 1'b1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0; req_acq = 0; req_rel = 0; req_kern = 0;
    endtask

    task automatic ack_wb(input int n);
        if (n > 0) begin
            @(negedge clk); wb_ack = 1'b1;
            repeat (n) @(negedge clk);
            wb_ack = 1'b0;
        end
    endtask

    task automatic ack_inv(input int n);
        if (n > 0) begin
            @(negedge clk); inv_ack = 1'b1;
            repeat (n) @(negedge clk);
            inv_ack = 1'b0;
        end
    endtask

    typedef struct packed {
        logic       acq;
        logic       rel;
        logic       kern;
        logic [2:0] ctx;
        logic [7:0] exp_inv;
        logic [7:0] exp_flush;
        logic [1:0] exp_iss;
        logic [7:0] exp_mask;
    } vec_t;

    // Main-function table: plain, acquire, release, acq+rel, kernel-begin, kernel-end.
    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 8'd0,  2'd1, 8'h00},
        '{1'b1, 1'b0, 1'b0, 3'd0, 8'd8, 8'd0,  2'd1, 8'h00},
        '{1'b0, 1'b1, 1'b0, 3'd0, 8'd0, 8'd8,  2'd1, 8'h00},
        '{1'b1, 1'b1, 1'b0, 3'd0, 8'd8, 8'd8,  2'd1, 8'h00},
        '{1'b1, 1'b0, 1'b1, 3'd1, 8'd8, 8'd0,  2'd1, 8'h00},
        '{1'b0, 1'b1, 1'b1, 3'd6, 8'd0, 8'd8,  2'd0, 8'h40}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic acc;
        rst = 1'b1; req_valid = 0; req_acq = 0; req_rel = 0; req_kern = 0; req_ctx = '0;
        iss_ready = 1'b1; mnt_ready = 1'b1; wb_ack = 0; inv_ack = 0;
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check(wb_outstanding == 0 && inv_outstanding == 0, "R12 counts after reset", int'(wb_outstanding) + int'(inv_outstanding), 0);
        check(!mnt_valid && !iss_valid && !kend_done && !wb_err, "R12 outputs after reset",
              int'({mnt_valid, iss_valid, kend_done, wb_err}), 0);

        // Main table: R1 R2 R3 R7 R10
        for (int v = 0; v < 6; v++) begin
            clear_mon();
            do_req(VEC[v].acq, VEC[v].rel, VEC[v].kern, int'(VEC[v].ctx), acc);
            repeat (20) @(negedge clk);
            check(acc, "R1/R2 request accepted", int'(acc), 1);
            check(inv_seen == int'(VEC[v].exp_inv), "R2 invalidate handshakes", inv_seen, int'(VEC[v].exp_inv));
            check(flush_seen == int'(VEC[v].exp_flush), "R1 flush handshakes", flush_seen, int'(VEC[v].exp_flush));
            check(seq_bad == 0, "R3 walk order", seq_bad, 0);
            check(iss_seen == int'(VEC[v].exp_iss), "R10 issue routing", iss_seen, int'(VEC[v].exp_iss));
            check(int'(wb_outstanding) == int'(VEC[v].exp_flush), "R1 wb count", int'(wb_outstanding), int'(VEC[v].exp_flush));
            check(int'(inv_outstanding) == int'(VEC[v].exp_inv), "R2 inv count", int'(inv_outstanding), int'(VEC[v].exp_inv));
            ack_wb(int'(VEC[v].exp_flush));
            ack_inv(int'(VEC[v].exp_inv));
            repeat (2) @(negedge clk);
            check(wb_outstanding == 0 && inv_outstanding == 0, "R5 counts drain", int'(wb_outstanding), 0);
            check(last_mask == VEC[v].exp_mask, "R7 completion mask", int'(last_mask), int'(VEC[v].exp_mask));
        end

        // R1: maintenance held under back-pressure; R12: no accept during walk
        clear_mon();
        mnt_ready = 1'b0;
        do_req(1'b0, 1'b1, 1'b0, 0, acc);
        req_valid = 1'b1; req_kern = 1'b1; req_rel = 1'b1; req_ctx = 3'd3;
        #1;
        check(!req_ready, "R12 no accept mid-walk", int'(req_ready), 0);
        req_valid = 1'b0; req_kern = 1'b0; req_rel = 1'b0;
        repeat (3) @(negedge clk);
        check(mnt_valid && mnt_op && mnt_line == 0 && wb_outstanding == 0, "R1 hold under back-pressure",
              int'(mnt_line), 0);
        mnt_ready = 1'b1;
        repeat (12) @(negedge clk);
        check(wb_outstanding == 8, "R1 wb count after held walk", int'(wb_outstanding), 8);

        // R4: issue blocked until flush count drains
        req_valid = 1'b1;
        #1;
        check(!req_ready && !iss_valid, "R4 issue blocked", int'(iss_valid), 0);
        wb_ack = 1'b1;
        repeat (7) @(negedge clk);
        wb_ack = 1'b0;
        #1;
        check(!iss_valid && wb_outstanding == 1, "R4 still blocked at count 1", int'(wb_outstanding), 1);
        @(negedge clk); wb_ack = 1'b1;
        @(negedge clk); wb_ack = 1'b0;
        #1;
        check(iss_valid && req_ready, "R4 issue resumes", int'(iss_valid), 1);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;

        // R6: outstanding invalidates do not block
        clear_mon();
        do_req(1'b1, 1'b0, 1'b0, 0, acc);
        repeat (12) @(negedge clk);
        req_valid = 1'b1;
        #1;
        check(iss_valid && req_ready && inv_outstanding == 8, "R6 issue with inv pending", int'(iss_valid), 1);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        ack_inv(3);
        #1;
        check(inv_outstanding == 5 && wb_outstanding == 0 && !wb_err, "R6 inv ack only decrements", int'(inv_outstanding), 5);
        ack_inv(5);

        // R8 R9 R7: kernel requests during flush
        clear_mon();
        do_req(1'b0, 1'b1, 1'b0, 0, acc);
        repeat (12) @(negedge clk);
        clear_mon();
        do_req(1'b0, 1'b1, 1'b1, 2, acc);
        check(acc, "R8 kernel-end accepted mid-flush", int'(acc), 1);
        do_req(1'b0, 1'b1, 1'b1, 5, acc);
        repeat (3) @(negedge clk);
        check(flush_seen == 0 && wb_outstanding == 8 && iss_seen == 0 && done_seen == 0,
              "R8 kernel-end only recorded", flush_seen, 0);
        do_req(1'b1, 1'b0, 1'b1, 0, acc);
        repeat (12) @(negedge clk);
        check(inv_seen == 8, "R9 kernel-begin walks when inv idle", inv_seen, 8);
        do_req(1'b1, 1'b0, 1'b1, 0, acc);
        repeat (12) @(negedge clk);
        check(inv_seen == 8 && inv_outstanding == 8, "R9 kernel-begin suppressed", inv_seen, 8);
        ack_wb(8);
        repeat (2) @(negedge clk);
        check(done_seen == 1, "R7 single completion pulse", done_seen, 1);
        check(last_mask == 8'b0010_0100, "R7 batched mask", int'(last_mask), 36);
        ack_inv(8);

        // R11: pending list full
        clear_mon();
        do_req(1'b0, 1'b1, 1'b0, 0, acc);
        repeat (12) @(negedge clk);
        for (int c = 0; c < 4; c++) do_req(1'b0, 1'b1, 1'b1, c, acc);
        req_valid = 1'b1; req_kern = 1'b1; req_rel = 1'b1; req_ctx = 3'd4;
        repeat (3) @(negedge clk);
        #1;
        check(!req_ready, "R11 full list back-pressure", int'(req_ready), 0);
        req_valid = 1'b0; req_kern = 1'b0; req_rel = 1'b0;
        ack_wb(8);
        repeat (2) @(negedge clk);
        check(last_mask == 8'h0F && done_seen == 1, "R11 list contents on drain", int'(last_mask), 15);

        // R5: acknowledge at zero
        @(negedge clk); wb_ack = 1'b1;
        #1;
        check(wb_err, "R5 underflow flagged", int'(wb_err), 1);
        @(negedge clk); wb_ack = 1'b0;
        #1;
        check(wb_outstanding == 0 && !wb_err, "R5 count stays zero", int'(wb_outstanding), 0);

        // R10: kernel-begin refused by issue path starts no walk
        clear_mon();
        iss_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kern = 1'b1; req_acq = 1'b1;
        #1;
        check(iss_valid && !req_ready, "R10 kernel-begin offered to issue", int'(iss_valid), 1);
        repeat (4) @(negedge clk);
        check(inv_seen == 0 && inv_outstanding == 0, "R10 no walk before accept", inv_seen, 0);
        iss_ready = 1'b1;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0; req_kern = 1'b0; req_acq = 1'b0;
        repeat (12) @(negedge clk);
        check(inv_seen == 8, "R10 walk after accept", inv_seen, 8);
        ack_inv(8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule